// File: doc/BRIEF.md
# Random-Access Scan State Array

This block holds a bank of state flip-flops that a tester can reach one cell at a time by address rather than by shifting a whole chain. A small address register is filled one bit per clock while a shift strobe is high, most significant bit first. A decoder turns that register into a one-hot select. In test mode only the selected cell takes the scan-in bit on the clock edge, and the scan-out pin always shows the value of the selected cell. In normal mode the array behaves like a plain register bank and every cell captures its functional input.

Writing a single addressed cell gives a single-input-change stimulus for delay testing. It also keeps the test sequence short, because only the cells that differ between patterns have to be touched. An address at or above the cell count selects nothing. A one-cycle status pulse tells the tester that a complete new address has been shifted in.

Top module: `ras_cell_array`

## Requirements
- R1: A clock edge with rst_n low clears every cell, the address register and the shift counter. After it, func_q is 0, scan_out is 0 and addr_ready is 0.
- R2: Each clock edge with addr_shift high shifts addr_sin into the address LSB, moving the older bits up, so a full address is sent MSB first. With addr_shift low the address does not change, whatever addr_sin does.
- R3: At most one cell is selected at any time. Address value i, for i below N_CELLS, selects cell i.
- R4: In test mode (test_mode = 1) the selected cell loads scan_in on the clock edge.
- R5: In test mode every unselected cell keeps its value, so one write changes at most one bit of func_q.
- R6: scan_out equals the current value of the selected cell, with no clock delay.
- R7: An address of N_CELLS or more selects no cell. scan_out is then 0, and a test-mode edge changes no cell.
- R8: In normal mode (test_mode = 0) every cell captures its bit of func_d on the clock edge, whatever the address holds.
- R9: addr_ready is high for exactly one cycle, the cycle after the edge that completes ADDR_W shifts counted since reset or since the previous pulse. Fewer shifts give no pulse.
- R10: On an edge with addr_shift high no cell changes, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cells and the address register |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | 1 = addressed scan access, 0 = functional capture |
| scan_in | input | 1 | Bit written into the selected cell in test mode |
| scan_out | output | 1 | Value of the selected cell, 0 when nothing is selected |
| addr_shift | input | 1 | Shift strobe for the address register |
| addr_sin | input | 1 | Serial address bit, MSB first |
| addr_ready | output | 1 | One-cycle pulse after a complete address has been shifted in |
| func_d | input | N_CELLS | Functional next-state inputs |
| func_q | output | N_CELLS | Cell contents driven to the functional logic |

## Verification
On every cycle the assertions check several rules: the select stays one-hot or empty, scan-out follows the addressed cell, out-of-range addresses stay silent, and normal mode captures the whole bus. They also check that a test-mode write touches only the selected bit, that the array is frozen while the address shifts, that the address register shifts correctly, and that the ready pulse lasts one cycle. Other behaviour can only be shown by the bench's scenarios: that a particular serial bit order lands on the intended cell, that the pulse waits for a full address after reset, and that holding the strobe low keeps the address even while addr_sin toggles and test writes land.

// File: rtl/ras_pkg.sv
// Shared helpers for the random-access scan array.
// Assumes cell counts of three or more, so the address is at least two bits wide.
package ras_pkg;

    // Address bits needed to name every cell.
    function automatic int unsigned addr_bits(input int unsigned n_cells);
        return (n_cells < 4) ? 2 : $clog2(n_cells);
    endfunction

    // Access mode of the array.
    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_SCAN = 1'b1
    } ras_mode_e;

endpackage

// File: rtl/ras_addr_shift.sv
// Serial address register with a completion pulse.
// Shifts ser_in into the LSB on each enabled edge. After ADDR_W shifts it
// raises ready for one cycle and restarts the count.
// Assumes ADDR_W >= 2 and a synchronous active-low reset.
module ras_addr_shift #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam int unsigned CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

    logic [CNT_W-1:0] shift_cnt;

    // Shift the address register MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (shift_en)
            addr <= {addr[ADDR_W-2:0], ser_in};
    end

    // Count shifts and pulse ready when a full address has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_cnt <= '0;
            ready     <= 1'b0;
        end else if (shift_en && shift_cnt == LAST) begin
            shift_cnt <= '0;
            ready     <= 1'b1;
        end else begin
            if (shift_en)
                shift_cnt <= shift_cnt + 1'b1;
            ready <= 1'b0;
        end
    end

endmodule

// File: rtl/ras_sel_decode.sv
// Address decoder: one select line per cell.
// Addresses at or above N_CELLS drive no select line.
module ras_sel_decode #(
    parameter int unsigned N_CELLS = 6,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_CELLS-1:0] sel
);
    // One comparator per cell.
    for (genvar i = 0; i < N_CELLS; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/ras_state_cell.sv
// One state cell of the array.
// Normal mode captures func_d. Scan mode writes scan_bit only when selected.
// hold freezes the cell in both modes.
module ras_state_cell
    import ras_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  ras_mode_e mode,
    input  logic      sel,
    input  logic      scan_bit,
    input  logic      func_d,
    output logic      q
);
    // Next-state choice between functional capture and addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (!hold) begin
            if (mode == MODE_FUNC)
                q <= func_d;
            else if (sel)
                q <= scan_bit;
        end
    end

endmodule

// File: rtl/ras_scan_mux.sv
// Read-out path: AND-OR of the cells with the one-hot select.
// Gives 0 when no select line is active.
module ras_scan_mux #(
    parameter int unsigned N_CELLS = 6
) (
    input  logic [N_CELLS-1:0] cells,
    input  logic [N_CELLS-1:0] sel,
    output logic               bit_out
);
    // Reduce the masked cells to one bit.
    always_comb bit_out = |(cells & sel);

endmodule

// File: rtl/ras_cell_array.sv
// Random-access scan state array (top level).
// A serial address register and a decoder pick one cell. In scan mode that
// cell is written from scan_in and read on scan_out. In normal mode all cells
// load func_d. The array holds while the address is shifting.
// Assumes a single clock and a synchronous active-low reset.
module ras_cell_array
    import ras_pkg::*;
#(
    parameter int unsigned N_CELLS = 6,
    parameter int unsigned ADDR_W  = ras_pkg::addr_bits(N_CELLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_mode,
    input  logic               scan_in,
    output logic               scan_out,
    input  logic               addr_shift,
    input  logic               addr_sin,
    output logic               addr_ready,
    input  logic [N_CELLS-1:0] func_d,
    output logic [N_CELLS-1:0] func_q
);
    logic [ADDR_W-1:0]  addr_q;
    logic [N_CELLS-1:0] sel;
    ras_mode_e          mode;

    // Map the test-control pin onto the mode type.
    always_comb mode = test_mode ? MODE_SCAN : MODE_FUNC;

    ras_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (addr_shift),
        .ser_in   (addr_sin),
        .addr     (addr_q),
        .ready    (addr_ready)
    );

    ras_sel_decode #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr_q),
        .sel  (sel)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        ras_state_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (addr_shift),
            .mode     (mode),
            .sel      (sel[i]),
            .scan_bit (scan_in),
            .func_d   (func_d[i]),
            .q        (func_q[i])
        );
    end

    ras_scan_mux #(.N_CELLS(N_CELLS)) u_mux (
        .cells   (func_q),
        .sel     (sel),
        .bit_out (scan_out)
    );

endmodule

// File: rtl/ras_cell_array_chk.sv
// Property checker for ras_cell_array, attached by bind.
// Watches the ports together with the address register and the select bus.
module ras_cell_array_chk #(
    parameter int unsigned N_CELLS = 6,
    parameter int unsigned ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_mode,
    input logic               scan_in,
    input logic               scan_out,
    input logic               addr_shift,
    input logic               addr_sin,
    input logic               addr_ready,
    input logic [N_CELLS-1:0] func_d,
    input logic [N_CELLS-1:0] func_q,
    input logic [ADDR_W-1:0]  addr_q,
    input logic [N_CELLS-1:0] sel
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(N_CELLS);

    // R2: a strobed edge takes addr_sin into the LSB
    p_addr_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_shift |=> addr_q[0] == $past(addr_sin));
    // R2: without the strobe the address is unchanged
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_shift |=> $stable(addr_q));
    // R3: select is one-hot or empty
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R4: a selected cell takes scan_in
    p_scan_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !addr_shift && (|sel)) |=> ((|(func_q & $past(sel))) == $past(scan_in)));
    // R5: unselected cells keep their value in test mode
    p_scan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !addr_shift) |=> ((func_q & ~$past(sel)) == ($past(func_q) & ~$past(sel))));
    // R6: scan_out follows the addressed cell
    p_scan_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr_q} < LIMIT) |-> (scan_out == func_q[addr_q]));
    // R7: an out-of-range address selects nothing and reads 0
    p_oob_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr_q} >= LIMIT) |-> (sel == '0 && !scan_out));
    // R8: normal mode captures the whole functional bus
    p_func_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !addr_shift) |=> (func_q == $past(func_d)));
    // R9: the ready pulse is one cycle long
    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ready |=> !addr_ready);
    // R9: the ready pulse only follows a shift
    p_ready_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ready |-> $past(addr_shift));
    // R10: the array is frozen while the address shifts
    p_shift_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_shift |=> $stable(func_q));

endmodule

bind ras_cell_array ras_cell_array_chk #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .addr_shift (addr_shift),
    .addr_sin   (addr_sin),
    .addr_ready (addr_ready),
    .func_d     (func_d),
    .func_q     (func_q),
    .addr_q     (addr_q),
    .sel        (sel)
);

// File: tb/tb_ras_cell_array.sv
// Self-checking bench for ras_cell_array: a vector table, then directed cases.
module tb_ras_cell_array;
    localparam int N = 6;
    localparam int W = 3;
    localparam int NV = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic scan_in = 1'b0;
    logic addr_shift = 1'b0;
    logic addr_sin = 1'b0;
    logic [N-1:0] func_d = '0;
    logic scan_out;
    logic addr_ready;
    logic [N-1:0] func_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ras_cell_array #(.N_CELLS(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .addr_shift (addr_shift),
        .addr_sin   (addr_sin),
        .addr_ready (addr_ready),
        .func_d     (func_d),
        .func_q     (func_q)
    );

    // Entry layout: {addr, test_mode, scan_in, func_d, expected func_q, expected scan_out}
    localparam logic [17:0] VEC [NV] = '{
        {3'd2, 1'b1, 1'b1, 6'b000000, 6'b000100, 1'b1},
        {3'd5, 1'b1, 1'b1, 6'b000000, 6'b100100, 1'b1},
        {3'd2, 1'b1, 1'b0, 6'b111111, 6'b100000, 1'b0},
        {3'd6, 1'b1, 1'b1, 6'b000000, 6'b100000, 1'b0},
        {3'd7, 1'b1, 1'b1, 6'b000000, 6'b100000, 1'b0},
        {3'd0, 1'b0, 1'b0, 6'b101011, 6'b101011, 1'b1},
        {3'd6, 1'b0, 1'b1, 6'b010110, 6'b010110, 1'b0},
        {3'd1, 1'b1, 1'b0, 6'b000000, 6'b010100, 1'b0},
        {3'd4, 1'b1, 1'b0, 6'b111111, 6'b000100, 1'b0},
        {3'd3, 1'b0, 1'b0, 6'b111111, 6'b111111, 1'b1},
        {3'd3, 1'b1, 1'b0, 6'b000000, 6'b110111, 1'b0}
    };

    // Compare one value and report a failure.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift a full address MSB first; ends at a falling edge.
    task automatic shift_addr(input logic [W-1:0] a);
        for (int i = W - 1; i >= 0; i--) begin
            addr_shift = 1'b1;
            addr_sin   = a[i];
            @(posedge clk);
            @(negedge clk);
        end
        addr_shift = 1'b0;
    endtask

    // Run one clock with the given controls; ends at a falling edge.
    task automatic step(input logic tm, input logic si, input logic [N-1:0] d);
        test_mode = tm;
        scan_in   = si;
        func_d    = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 q after reset", 32'(func_q), 32'h0);
        chk("R1 scan_out after reset", 32'(scan_out), 32'h0);
        chk("R1 ready after reset", 32'(addr_ready), 32'h0);

        // R9: two shifts give no pulse, the third does, and it lasts one cycle
        addr_shift = 1'b1; addr_sin = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 no pulse after 1 shift", 32'(addr_ready), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R9 no pulse after 2 shifts", 32'(addr_ready), 32'h0);
        addr_sin = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 pulse after 3 shifts", 32'(addr_ready), 32'h1);
        addr_shift = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 pulse ends", 32'(addr_ready), 32'h0);
        // R7: address 6 is out of range
        chk("R7 oob scan_out", 32'(scan_out), 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [17:0] e;
            e = VEC[v];
            shift_addr(e[17:15]);
            chk("R9 pulse per full address", 32'(addr_ready), 32'h1);
            step(e[14], e[13], e[12:7]);
            chk($sformatf("R4 R5 R7 R8 vector %0d q", v), 32'(func_q), 32'(e[6:1]));
            chk($sformatf("R3 R6 R7 vector %0d scan_out", v), 32'(scan_out), 32'(e[0]));
        end

        // R2: toggling addr_sin without the strobe keeps address 3
        for (int k = 0; k < 3; k++) begin
            addr_sin = ~addr_sin;
            step(1'b1, 1'b1, '0);
        end
        chk("R2 address held without strobe", 32'(func_q), 32'h3F);
        chk("R2 R6 scan_out of cell 3", 32'(scan_out), 32'h1);

        // R10: a shifting edge in normal mode does not capture func_d
        test_mode  = 1'b0;
        func_d     = '0;
        addr_shift = 1'b1;
        addr_sin   = 1'b0;
        @(posedge clk); @(negedge clk);
        addr_shift = 1'b0;
        chk("R10 frozen while shifting", 32'(func_q), 32'h3F);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 q after second reset", 32'(func_q), 32'h0);
        chk("R1 ready after second reset", 32'(addr_ready), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule